// File: doc/BRIEF.md
# Block Cipher Round Key Schedule Generator

This block turns a 128-, 192- or 256-bit cipher key into the complete round key schedule of the standard 128-bit block cipher, 4*(Nr+1) words of 32 bits, with Nr = 10, 12 or 14. After a start strobe it computes one word per clock and writes it into an internal word store. A separate combinational read port then returns any round key, as a 128-bit value, from its round number.

With the decrypt flag set at start, a second pass runs after expansion. It applies the inverse column mix to every round key except the first and the last, so the store holds the schedule for the equivalent inverse cipher. The pass handles one 32-bit column per cycle. The cipher data path that consumes the keys is not part of this block.

Top module: `kx_key_expand`

## Requirements
- R1: While reset is held, and right after it is released, `busy` and `done` are both 0.
- R2: `key_size` = 2'b00 selects a 128-bit key (Nk=4, Nr=10). The key occupies `key_in[255:128]`. Key word 0 sits in the upper 32 bits of the used part, and byte 0 of each word is its top byte. Round key r read back equals words 4r..4r+3 of the standard expansion, with word 4r in `rd_key[127:96]`. For the all-zero key, round key 10 is b4ef5bcb3e92e21123e951cf6f8f188e.
- R3: `key_size` = 2'b01 selects a 192-bit key taken from `key_in[255:64]` (Nk=6, Nr=12), expanded by the same rule with the round constant used every sixth word.
- R4: `key_size` = 2'b10 or 2'b11 selects a 256-bit key (Nk=8, Nr=14). Words whose index is 4 mod 8 get the extra byte substitution without rotation or round constant.
- R5: `decrypt` = 1 at start makes round keys 1..Nr-1 read back as the inverse column mix of their encrypt value, applied to each 32-bit column. Round keys 0 and Nr are unchanged.
- R6: `busy` is 1 from the cycle after the start edge until `done`. `done` is a one-cycle pulse that appears 4*(Nr+1) cycles after the start edge when encrypting and 8*Nr cycles after it when decrypting. `busy` is 0 while `done` is 1.
- R7: A `start` while `busy` is 1 is ignored. The key, size and mode it carries change neither the completion time nor the stored schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin expansion of `key_in` (accepted only when idle) |
| key_size | input | 2 | 00: 128-bit, 01: 192-bit, 1x: 256-bit key |
| decrypt | input | 1 | 1: build the inverse-cipher schedule |
| key_in | input | 256 | Cipher key, left-aligned |
| busy | output | 1 | Expansion or post-pass in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_round | input | 4 | Round number to read |
| rd_key | output | 128 | Round key of `rd_round` (combinational) |

## Verification
Each expanded word depends on the word before it and on the word Nk places back. A wrong round constant, a wrong position counter or a faulty substitution therefore corrupts the word where it happens and every later word. The last round key always shows the error as soon as `done` rises. A slip in the step counter or in the end-of-run compare moves `done` off its exact cycle count. A config register that reloads while busy shows up when the injected mid-run start alters the final schedule. A wrong post-pass range appears as round 0 or round Nr being transformed, or as a middle round left untouched.

// File: rtl/kx_pkg.sv
package kx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXPAND = 2'd1,
    ST_INVMIX = 2'd2
  } kx_state_e;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // a^254 is the field inverse (and maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p;
    logic [7:0] r;
    p = a;
    r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/kx_sub_word.sv
module kx_sub_word (
  input  logic [31:0] word_i,
  output logic [31:0] word_o
);
  for (genvar g = 0; g < 4; g++) begin : g_byte
    assign word_o[8*g +: 8] = kx_pkg::sbox_fwd(word_i[8*g +: 8]);
  end
endmodule

// File: rtl/kx_inv_mix_col.sv
module kx_inv_mix_col (
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  logic [7:0] a [4];

  for (genvar g = 0; g < 4; g++) begin : g_split
    assign a[g] = col_i[31-8*g -: 8];
  end

  // row j: 0e*a[j] ^ 0b*a[j+1] ^ 0d*a[j+2] ^ 09*a[j+3]
  for (genvar j = 0; j < 4; j++) begin : g_row
    assign col_o[31-8*j -: 8] = kx_pkg::gf_mul(a[j],         8'h0e) ^
                                kx_pkg::gf_mul(a[(j+1) % 4], 8'h0b) ^
                                kx_pkg::gf_mul(a[(j+2) % 4], 8'h0d) ^
                                kx_pkg::gf_mul(a[(j+3) % 4], 8'h09);
  end
endmodule

// File: rtl/kx_word_ram.sv
module kx_word_ram #(
  parameter int DEPTH = 60,
  parameter int WIDTH = 32,
  parameter int AW    = 6,
  parameter int BW    = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [WIDTH-1:0]   wdata,
  input  logic [AW-1:0]      ra_a,
  output logic [WIDTH-1:0]   rd_a,
  input  logic [AW-1:0]      ra_b,
  output logic [WIDTH-1:0]   rd_b,
  input  logic [BW-1:0]      blk,
  output logic [4*WIDTH-1:0] rd_blk
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rd_a = (32'(ra_a) < DEPTH) ? mem_q[ra_a] : '0;
  assign rd_b = (32'(ra_b) < DEPTH) ? mem_q[ra_b] : '0;

  for (genvar j = 0; j < 4; j++) begin : g_blk
    logic [AW-1:0] ba;
    assign ba = AW'({blk, 2'b00}) + AW'(j);
    assign rd_blk[4*WIDTH-1-WIDTH*j -: WIDTH] = (32'(ba) < DEPTH) ? mem_q[ba] : '0;
  end
endmodule

// File: rtl/kx_key_expand.sv
module kx_key_expand #(
  parameter int KEY_W  = 256,
  parameter int MAX_NR = 14,
  localparam int MAX_WORDS = 4 * (MAX_NR + 1),
  localparam int AW        = $clog2(MAX_WORDS),
  localparam int RW        = $clog2(MAX_NR + 1),
  localparam int MAX_NK    = KEY_W / 32,
  localparam int KSEL      = $clog2(MAX_NK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       key_size,
  input  logic             decrypt,
  input  logic [KEY_W-1:0] key_in,
  output logic             busy,
  output logic             done,
  input  logic [RW-1:0]    rd_round,
  output logic [127:0]     rd_key
);
  import kx_pkg::*;

  kx_state_e        state_q, state_d;
  logic [AW-1:0]    idx_q, idx_d;
  logic [3:0]       kmod_q, kmod_d;
  logic [7:0]       rcon_q, rcon_d;
  logic [KEY_W-1:0] key_q;
  logic [3:0]       nk_q, nk_sel;
  logic [RW-1:0]    nr_q, nr_sel;
  logic             dec_q;
  logic             done_q, done_d;

  logic             cfg_en, ctr_en;
  logic [AW-1:0]    last_word, mix_last;
  logic [31:0]      key_word [MAX_NK];
  logic [31:0]      prev_w, back_w, sub_in, sub_out, imc_out, temp_w, wdata;
  logic [AW-1:0]    ra_a, ra_b;
  logic             we;

  // ---------------- key size decode ----------------
  always_comb begin
    unique casez (key_size)
      2'b00:   begin nk_sel = 4'd4; nr_sel = RW'(10); end
      2'b01:   begin nk_sel = 4'd6; nr_sel = RW'(12); end
      default: begin nk_sel = 4'd8; nr_sel = RW'(14); end
    endcase
  end

  for (genvar g = 0; g < MAX_NK; g++) begin : g_kw
    assign key_word[g] = key_q[KEY_W-1-32*g -: 32];
  end

  assign last_word = AW'({nr_q, 2'b11});
  assign mix_last  = AW'({nr_q, 2'b00}) - AW'(1);

  // ---------------- word datapath ----------------
  assign ra_a   = (state_q == ST_EXPAND) ? idx_q - AW'(1) : idx_q;
  assign ra_b   = idx_q - AW'(nk_q);
  assign sub_in = (kmod_q == 4'd0) ? {prev_w[23:0], prev_w[31:24]} : prev_w;

  kx_sub_word u_sub (
    .word_i (sub_in),
    .word_o (sub_out)
  );

  kx_inv_mix_col u_imc (
    .col_i (prev_w),
    .col_o (imc_out)
  );

  always_comb begin
    if (kmod_q == 4'd0)
      temp_w = sub_out ^ {rcon_q, 24'h000000};
    else if (nk_q == 4'd8 && kmod_q == 4'd4)
      temp_w = sub_out;
    else
      temp_w = prev_w;
  end

  always_comb begin
    if (state_q == ST_INVMIX)
      wdata = imc_out;
    else if (idx_q < AW'(nk_q))
      wdata = key_word[idx_q[KSEL-1:0]];
    else
      wdata = back_w ^ temp_w;
  end

  assign we = (state_q != ST_IDLE);

  kx_word_ram #(
    .DEPTH (MAX_WORDS),
    .WIDTH (32),
    .AW    (AW),
    .BW    (RW)
  ) u_ram (
    .clk    (clk),
    .we     (we),
    .waddr  (idx_q),
    .wdata  (wdata),
    .ra_a   (ra_a),
    .rd_a   (prev_w),
    .ra_b   (ra_b),
    .rd_b   (back_w),
    .blk    (rd_round),
    .rd_blk (rd_key)
  );

  // ---------------- next state ----------------
  assign cfg_en = (state_q == ST_IDLE) && start;
  assign ctr_en = (state_q != ST_IDLE) || start;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    kmod_d  = kmod_q;
    rcon_d  = rcon_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_EXPAND;
          idx_d   = '0;
          kmod_d  = 4'd0;
          rcon_d  = 8'h01;
        end
      end
      ST_EXPAND: begin
        idx_d  = idx_q + AW'(1);
        kmod_d = (kmod_q == nk_q - 4'd1) ? 4'd0 : kmod_q + 4'd1;
        if (idx_q >= AW'(nk_q) && kmod_q == 4'd0) rcon_d = gf_xtime(rcon_q);
        if (idx_q == last_word) begin
          if (dec_q) begin
            state_d = ST_INVMIX;
            idx_d   = AW'(4);
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_INVMIX: begin
        idx_d = idx_q + AW'(1);
        if (idx_q == mix_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      kmod_q <= 4'd0;
      rcon_q <= 8'h00;
    end else if (ctr_en) begin
      idx_q  <= idx_d;
      kmod_q <= kmod_d;
      rcon_q <= rcon_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      nk_q  <= 4'd4;
      nr_q  <= RW'(10);
      dec_q <= 1'b0;
    end else if (cfg_en) begin
      key_q <= key_in;
      nk_q  <= nk_sel;
      nr_q  <= nr_sel;
      dec_q <= decrypt;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // ---------------- assertions ----------------
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE) && ($past(state_q) != ST_IDLE)); // R6

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (idx_q <= last_word)); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(key_q) && $stable(nk_q) && $stable(dec_q)); // R7

  AST_KMOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXPAND) |-> (kmod_q < nk_q)); // R2

endmodule

// File: tb/sim_kx_key_expand.sv
module sim_kx_key_expand;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   key_size;
  logic         decrypt;
  logic [255:0] key_in;
  logic         busy;
  logic         done;
  logic [3:0]   rd_round;
  logic [127:0] rd_key;

  always #5 clk = ~clk;

  kx_key_expand u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .key_size (key_size),
    .decrypt  (decrypt),
    .key_in   (key_in),
    .busy     (busy),
    .done     (done),
    .rd_round (rd_round),
    .rd_key   (rd_key)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  exp_t [256];
  logic [7:0]  log_t [256];
  logic [7:0]  sb    [256];
  logic [31:0] ew    [60];

  // ---------------- reference math (log/antilog based) ----------------
  function automatic logic [7:0] rf_xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rf_mul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return exp_t[(int'(log_t[a]) + int'(log_t[b])) % 255];
  endfunction

  function automatic void build_tables();
    logic [7:0] e;
    e = 8'h01;
    for (int k = 0; k < 255; k++) begin
      exp_t[k] = e;
      log_t[e] = 8'(k);
      e = e ^ rf_xt(e);
    end
    exp_t[255] = 8'h01;
    log_t[0]   = 8'h00;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v;
      if (x == 0) v = 8'h00;
      else v = exp_t[(255 - int'(log_t[x])) % 255];
      sb[x] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
              {v[3:0], v[7:4]} ^ 8'h63;
    end
  endfunction

  function automatic logic [31:0] rf_subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [31:0] rf_imc(input logic [31:0] c);
    logic [7:0] a [4];
    logic [31:0] r;
    for (int g = 0; g < 4; g++) a[g] = c[31-8*g -: 8];
    for (int j = 0; j < 4; j++)
      r[31-8*j -: 8] = rf_mul(a[j], 8'h0e) ^ rf_mul(a[(j+1)%4], 8'h0b) ^
                       rf_mul(a[(j+2)%4], 8'h0d) ^ rf_mul(a[(j+3)%4], 8'h09);
    return r;
  endfunction

  function automatic void rf_expand(input logic [255:0] key, input int nk, input int nr);
    logic [7:0]  rc;
    logic [31:0] t;
    rc = 8'h01;
    for (int i = 0; i < nk; i++) ew[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      t = ew[i-1];
      if (i % nk == 0) begin
        t = rf_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = rf_xt(rc);
      end else if (nk == 8 && i % nk == 4) begin
        t = rf_subw(t);
      end
      ew[i] = ew[i-nk] ^ t;
    end
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input logic [127:0] got,
                     input logic [127:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, expv);
    end
  endtask

  function automatic logic [255:0] rand_key();
    return {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic run_case(input logic [255:0] key, input logic [1:0] ks, input logic dec,
                          input int inject_at, input string req);
    int nk, nr, cnt, want;
    logic [127:0] ek;
    nk = (ks == 2'b00) ? 4 : (ks == 2'b01) ? 6 : 8;
    nr = (ks == 2'b00) ? 10 : (ks == 2'b01) ? 12 : 14;
    rf_expand(key, nk, nr);
    want = dec ? 8*nr : 4*(nr+1);

    @(negedge clk);
    key_in = key; key_size = ks; decrypt = dec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6", "busy after start", 128'(busy), 128'(1));
    cnt = 0;
    while (!done && cnt < 400) begin
      if (cnt == inject_at) begin
        start = 1'b1; key_in = ~key; key_size = ks + 2'd1; decrypt = ~dec;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk((inject_at >= 0) ? "R7" : "R6", "done cycle count", 128'(cnt), 128'(want));
    chk("R6", "busy low at done", 128'(busy), 128'(0));
    @(negedge clk);
    chk("R6", "done one cycle", 128'(done), 128'(0));

    for (int r = 0; r <= nr; r++) begin
      logic [31:0] w [4];
      for (int c = 0; c < 4; c++) begin
        w[c] = ew[4*r+c];
        if (dec && r != 0 && r != nr) w[c] = rf_imc(w[c]);
      end
      ek = {w[0], w[1], w[2], w[3]};
      rd_round = 4'(r);
      #1;
      chk(req, $sformatf("round %0d (size %0d dec %0d)", r, ks, dec), rd_key, ek);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd715517));
    build_tables();
    rst_n = 1'b0; start = 1'b0; key_size = 2'b00; decrypt = 1'b0;
    key_in = '0; rd_round = '0;

    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 128'(busy), 128'(0));
    chk("R1", "done in reset", 128'(done), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 128'(busy), 128'(0));
    chk("R1", "done after reset", 128'(done), 128'(0));

    // directed: all-zero 128-bit key, known last round key
    run_case('0, 2'b00, 1'b0, -1, "R2");
    rd_round = 4'd10;
    #1;
    chk("R2", "zero key round 10", rd_key, 128'hb4ef5bcb3e92e21123e951cf6f8f188e);

    // directed corners: all-ones keys, size code 2'b11
    run_case({256{1'b1}}, 2'b01, 1'b0, -1, "R3");
    run_case({256{1'b1}}, 2'b11, 1'b0, -1, "R4");

    // random keys across sizes and modes
    for (int it = 0; it < 3; it++) begin
      run_case(rand_key(), 2'b00, 1'b0, -1, "R2");
      run_case(rand_key(), 2'b01, 1'b0, -1, "R3");
      run_case(rand_key(), 2'b10, 1'b0, -1, "R4");
      run_case(rand_key(), 2'b00, 1'b1, -1, "R5");
      run_case(rand_key(), 2'b01, 1'b1, -1, "R5");
      run_case(rand_key(), 2'b10, 1'b1, -1, "R5");
    end

    // start while busy is ignored, in both phases
    run_case(rand_key(), 2'b00, 1'b0, 7, "R7");
    run_case(rand_key(), 2'b10, 1'b1, 70, "R7");
    run_case(rand_key(), 2'b01, 1'b1, 0, "R7");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule